// File: doc/BRIEF.md
# Multi-Timer Clock Prescaler Tree

This block produces the count-enable ticks for five PWM timer channels from a single peripheral clock. Two programmable 8-bit prescalers divide the clock. The first feeds channels 0 and 1, and the second feeds channels 2, 3 and 4. Each channel then applies its own power-of-two divider to its group's prescaled tick, or it takes a synchronised external tick instead.

Every output is a one-cycle enable pulse in the peripheral clock domain, not a derived clock, so the downstream counters stay fully synchronous. Configuration arrives as two register words with write strobes. The prescaler word holds both prescaler values. The selector word holds a 4-bit field per channel that encodes the divide ratio and the source choice together. A build-time option adds a pass-through (divide-by-1) setting to the channel selectors.

Top module: `pwm_tick_tree`

## Requirements
- R1: Reset clears both configuration words. Every channel then pulses once every 2 clock cycles (prescale ratio 1, channel divide /2).
- R2: A prescaler with value V produces one tick every V+1 clock cycles, for V from 0 to 255.
- R3: Prescaler word bits [7:0] set prescaler 0, which serves channels 0 and 1. Bits [15:8] set prescaler 1, which serves channels 2, 3 and 4.
- R4: The field for channel n is at selector-word bits [4n+3:4n]. Codes 0, 1, 2 and 3 divide the group's prescaled tick by 2, 4, 8 and 16. In these codes a channel pulse occurs only in a cycle that carries a prescaled tick.
- R5: Codes from 4 up select the external tick (codes from 5 up when the divide-by-1 option is built). External input 0 serves channels 0 and 1, and external input 1 serves channels 2 to 4. A channel in external mode never pulses while its input stays low.
- R6: Each external input passes through a two-flop synchroniser and a rising-edge detector. A low-to-high change on the pin gives exactly one pulse, visible in the second cycle after the pin changes, however long the level is held.
- R7: A new prescaler value takes effect only at that prescaler's next terminal count. The period in progress completes at its old length, and the new length follows.
- R8: With the divide-by-1 option built, code 4 passes the group's prescaled tick straight through. Without the option, code 4 selects the external tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_cfg_we | input | 1 | Write strobe for the prescaler word |
| pre_cfg_data | input | 16 | Prescaler word: [7:0] group 0, [15:8] group 1 |
| sel_cfg_we | input | 1 | Write strobe for the selector word |
| sel_cfg_data | input | 20 | Selector word: 4-bit field per channel |
| ext_tick_in | input | 2 | Asynchronous external tick inputs, one per group |
| tick_out | output | 5 | One-cycle count-enable pulse per channel |

## Verification
The bench builds two copies of the block side by side: one with the default parameters, and one with the divide-by-1 option enabled. Both are driven from the same inputs. The optioned copy brings the raw prescaled tick of a group out to a port through code 4. That makes the terminal-count reload timing of R7 directly measurable.

Comparing code 4 across the two copies shows that the encoding really changes with the option. Period measurements then cover both prescaler extremes, every divide code, and channels in both groups.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

    // Width of one per-channel selector field
    localparam int SEL_W     = 4;
    // Number of divide codes (2,4,8,16) below the source codes
    localparam int DIV_CODES = 4;
    // Width of the free-running per-channel divide counter
    localparam int DIV_CNT_W = DIV_CODES;

    typedef enum logic [1:0] {
        SRC_DIV  = 2'd0,   // divided prescaled tick
        SRC_PASS = 2'd1,   // prescaled tick passed straight through
        SRC_EXT  = 2'd2    // synchronised external tick
    } tick_src_e;

    typedef struct packed {
        tick_src_e  src;
        logic [1:0] div_log;   // log2(ratio) - 1 when src == SRC_DIV
    } chan_mode_t;

    function automatic chan_mode_t decode_sel(input logic [SEL_W-1:0] code,
                                              input logic             div1_en);
        chan_mode_t m;
        m.div_log = code[1:0];
        if (code < SEL_W'(DIV_CODES))
            m.src = SRC_DIV;
        else if (div1_en && code == SEL_W'(DIV_CODES))
            m.src = SRC_PASS;
        else
            m.src = SRC_EXT;
        return m;
    endfunction

    // Low-bit mask whose all-ones state marks the end of a divide period
    function automatic logic [DIV_CNT_W-1:0] div_mask(input logic [1:0] div_log);
        logic [DIV_CNT_W-1:0] m;
        for (int i = 0; i < DIV_CNT_W; i++)
            m[i] = (i <= int'(div_log));
        return m;
    endfunction

    // Prescaler group that serves a channel
    function automatic int group_of(input int ch, input int grp0_ch);
        return (ch < grp0_ch) ? 0 : 1;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] limit_i,
    output logic         tick_o,
    output logic [W-1:0] active_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] act_q;

    assign tick_o   = (cnt_q == act_q);
    assign active_o = act_q;

    // The programmed limit is adopted only at terminal count
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
            act_q <= limit_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_ext_edge.sv
module pwm_ext_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o
);
    logic [2:0] sh_q;   // [0],[1] synchroniser, [2] edge history

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[1:0], pin_i};
    end

    assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/pwm_chan_sel.sv
module pwm_chan_sel
    import pwm_tick_pkg::*;
#(
    parameter bit HAS_DIV1 = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_tick_i,
    input  logic             ext_tick_i,
    input  logic [SEL_W-1:0] code_i,
    output logic             tick_o
);
    logic [DIV_CNT_W-1:0] cnt_q;
    logic [DIV_CNT_W-1:0] mask;
    chan_mode_t           mode;
    logic                 div_hit;

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (pre_tick_i) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        mode    = decode_sel(code_i, HAS_DIV1);
        mask    = div_mask(mode.div_log);
        div_hit = pre_tick_i && ((cnt_q & mask) == mask);
        unique case (mode.src)
            SRC_DIV:  tick_o = div_hit;
            SRC_PASS: tick_o = pre_tick_i;
            default:  tick_o = ext_tick_i;
        endcase
    end
endmodule

// File: rtl/pwm_tick_tree.sv
module pwm_tick_tree
    import pwm_tick_pkg::*;
#(
    parameter int NUM_CH   = 5,
    parameter int PRE_W    = 8,
    parameter int GRP0_CH  = 2,
    parameter bit HAS_DIV1 = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pre_cfg_we,
    input  logic [2*PRE_W-1:0]       pre_cfg_data,
    input  logic                     sel_cfg_we,
    input  logic [NUM_CH*SEL_W-1:0]  sel_cfg_data,
    input  logic [1:0]               ext_tick_in,
    output logic [NUM_CH-1:0]        tick_out
);
    localparam int NUM_GRP    = 2;
    localparam int PRE_WORD_W = NUM_GRP * PRE_W;
    localparam int SEL_WORD_W = NUM_CH * SEL_W;

    logic [PRE_WORD_W-1:0] pre_word_q;
    logic [SEL_WORD_W-1:0] sel_word_q;
    logic [NUM_GRP-1:0]    pre_tick;
    logic [PRE_WORD_W-1:0] pre_lim;
    logic [NUM_GRP-1:0]    ext_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_word_q <= '0;
            sel_word_q <= '0;
        end else begin
            if (pre_cfg_we) pre_word_q <= pre_cfg_data;
            if (sel_cfg_we) sel_word_q <= sel_cfg_data;
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        pwm_prescaler #(.W(PRE_W)) pre_i (
            .clk      (clk),
            .rst      (rst),
            .limit_i  (pre_word_q[g*PRE_W +: PRE_W]),
            .tick_o   (pre_tick[g]),
            .active_o (pre_lim[g*PRE_W +: PRE_W])
        );
        pwm_ext_edge ext_i (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (ext_tick_in[g]),
            .rise_o (ext_edge[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int G = group_of(c, GRP0_CH);
        pwm_chan_sel #(.HAS_DIV1(HAS_DIV1)) sel_i (
            .clk        (clk),
            .rst        (rst),
            .pre_tick_i (pre_tick[G]),
            .ext_tick_i (ext_edge[G]),
            .code_i     (sel_word_q[c*SEL_W +: SEL_W]),
            .tick_o     (tick_out[c])
        );
    end
endmodule

// File: rtl/pwm_tick_tree_chk.sv
module pwm_tick_tree_chk #(
    parameter int NUM_CH   = 5,
    parameter int PRE_W    = 8,
    parameter int GRP0_CH  = 2,
    parameter bit HAS_DIV1 = 1'b0
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_CH*4-1:0]   sel_word_q,
    input logic [1:0]            pre_tick,
    input logic [2*PRE_W-1:0]    pre_lim,
    input logic [1:0]            ext_edge,
    input logic [1:0]            ext_tick_in,
    input logic [NUM_CH-1:0]     tick_out
);
    localparam logic [3:0] EXT_MIN = HAS_DIV1 ? 4'd5 : 4'd4;

    AST_RESET_RATIO_ONE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pre_lim == '0); // R1

    for (genvar p = 0; p < 2; p++) begin : g_p
        AST_LIMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
            !pre_tick[p] |=> $stable(pre_lim[p*PRE_W +: PRE_W])); // R7
        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            ext_edge[p] |=> !ext_edge[p]); // R6
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        localparam int G = (c < GRP0_CH) ? 0 : 1;
        AST_DIV_ON_PRESCALE: assert property (@(posedge clk) disable iff (rst)
            (sel_word_q[c*4 +: 4] < 4'd4 && tick_out[c]) |-> pre_tick[G]); // R4
        AST_EXT_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
            (sel_word_q[c*4 +: 4] >= EXT_MIN && tick_out[c])
            |-> $past(ext_tick_in[G], 2)); // R5
    end
endmodule

bind pwm_tick_tree pwm_tick_tree_chk #(
    .NUM_CH(NUM_CH), .PRE_W(PRE_W), .GRP0_CH(GRP0_CH), .HAS_DIV1(HAS_DIV1)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sel_word_q  (sel_word_q),
    .pre_tick    (pre_tick),
    .pre_lim     (pre_lim),
    .ext_edge    (ext_edge),
    .ext_tick_in (ext_tick_in),
    .tick_out    (tick_out)
);

// File: tb/pwm_tick_tree_tb_top.sv
module pwm_tick_tree_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pre_we = 1'b0;
    logic [15:0] pre_data = '0;
    logic        sel_we = 1'b0;
    logic [19:0] sel_data = '0;
    logic [1:0]  ext_in = '0;
    logic [4:0]  tick_a;
    logic [4:0]  tick_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_tick_tree dut_i (
        .clk(clk), .rst(rst), .pre_cfg_we(pre_we), .pre_cfg_data(pre_data),
        .sel_cfg_we(sel_we), .sel_cfg_data(sel_data), .ext_tick_in(ext_in),
        .tick_out(tick_a)
    );

    pwm_tick_tree #(.HAS_DIV1(1'b1)) dut_d1_i (
        .clk(clk), .rst(rst), .pre_cfg_we(pre_we), .pre_cfg_data(pre_data),
        .sel_cfg_we(sel_we), .sel_cfg_data(sel_data), .ext_tick_in(ext_in),
        .tick_out(tick_b)
    );

    // {prescaler word, channel, code, expected period}
    localparam logic [47:0] VEC [8] = '{
        {16'h0000, 8'd0, 8'd0, 16'd2},
        {16'h0003, 8'd0, 8'd1, 16'd16},
        {16'h0503, 8'd1, 8'd3, 16'd64},
        {16'h0503, 8'd2, 8'd0, 16'd12},
        {16'h0903, 8'd4, 8'd2, 16'd80},
        {16'hFF00, 8'd3, 8'd0, 16'd512},
        {16'h00FF, 8'd0, 8'd3, 16'd4096},
        {16'h0102, 8'd3, 8'd2, 16'd16}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_pre(input logic [15:0] v);
        pre_data = v; pre_we = 1'b1;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic write_sel(input logic [19:0] v);
        sel_data = v; sel_we = 1'b1;
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    function automatic bit pick(input bit alt, input int ch);
        return alt ? tick_b[ch] : tick_a[ch];
    endfunction

    // Cycles between two consecutive pulses on one channel
    task automatic measure(input bit alt, input int ch, output int per);
        int n;
        n = 0;
        do begin @(negedge clk); n++; end while (!pick(alt, ch) && n < 10000);
        n = 0;
        do begin @(negedge clk); n++; end while (!pick(alt, ch) && n < 10000);
        per = n;
    endtask

    // Pulses seen on one channel over a window of cycles
    task automatic count_pulses(input bit alt, input int ch, input int len, output int cnt);
        cnt = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (pick(alt, ch)) cnt++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int per, cnt_a, cnt_b, pos;
        @(negedge clk);
        do_reset();

        // R1: reset state on every channel
        for (int c = 0; c < 5; c++) begin
            measure(1'b0, c, per);
            check(per == 2, "R1 reset period", per, 2);
        end
        write_pre(16'h0505);
        do_reset();
        measure(1'b0, 2, per);
        check(per == 2, "R1 reset clears prescaler word", per, 2);

        // R2 R3 R4: vector table walk
        for (int i = 0; i < 8; i++) begin
            int ch, code, exp;
            ch   = int'(VEC[i][31:24]);
            code = int'(VEC[i][23:16]);
            exp  = int'(VEC[i][15:0]);
            do_reset();
            write_pre(VEC[i][47:32]);
            write_sel(20'(code) << (4 * ch));
            measure(1'b0, ch, per);
            measure(1'b0, ch, per);
            check(per == exp, "R2/R3/R4 vector period", per, exp);
        end

        // R5 R6: external ticks, ch1 on input 0 (code 4), ch3 on input 1 (code 9)
        do_reset();
        write_sel(20'h09040);
        repeat (4) @(negedge clk);
        ext_in[0] = 1'b1;
        cnt_a = 0; cnt_b = 0; pos = -1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (tick_a[1]) begin cnt_a++; pos = k; end
            if (tick_a[3]) cnt_b++;
        end
        check(cnt_a == 1, "R6 one pulse per held level", cnt_a, 1);
        check(pos == 2, "R6 pulse in second cycle", pos, 2);
        check(cnt_b == 0, "R5 input 0 does not reach group 1", cnt_b, 0);
        ext_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        cnt_a = 0; cnt_b = 0;
        for (int k = 0; k < 20; k++) begin
            ext_in[1] = (k < 12) && ((k % 4) < 2);
            @(negedge clk);
            if (tick_a[1]) cnt_a++;
            if (tick_a[3]) cnt_b++;
        end
        check(cnt_b == 3, "R6 three edges three pulses", cnt_b, 3);
        check(cnt_a == 0, "R5 input 1 does not reach group 0", cnt_a, 0);

        // R8: code 4 meaning depends on the build option
        do_reset();
        write_pre(16'h0200);
        write_sel(20'h00400);
        measure(1'b1, 2, per);
        check(per == 3, "R8 pass-through period", per, 3);
        count_pulses(1'b0, 2, 30, cnt_a);
        check(cnt_a == 0, "R8/R5 code 4 is external without option", cnt_a, 0);
        write_sel(20'h00500);
        count_pulses(1'b1, 2, 30, cnt_b);
        check(cnt_b == 0, "R5 code 5 is external with option", cnt_b, 0);

        // R7: reload only at terminal count, observed through pass-through
        do_reset();
        write_pre(16'h0009);
        write_sel(20'h00004);
        measure(1'b1, 0, per);
        check(per == 10, "R7 initial period", per, 10);
        pos = 0;
        do begin
            @(negedge clk);
            pos++;
            if (pos == 3) begin pre_data = 16'h0001; pre_we = 1'b1; end
            if (pos == 4) pre_we = 1'b0;
        end while (!tick_b[0] && pos < 100);
        check(pos == 10, "R7 period in progress not shortened", pos, 10);
        cnt_a = 0;
        do begin @(negedge clk); cnt_a++; end while (!tick_b[0] && cnt_a < 100);
        check(cnt_a == 2, "R7 new period after reload", cnt_a, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule